// File: doc/BRIEF.md
# Smart Card Bit-Rate and Card Clock Generator

This block produces the elementary-time timing for a smart card serial channel. It works only from the internal peripheral clock; no external timing source is accepted. Two settings control it: a sampling count S (0 to 2047) and a prescale count N (0 to 7). A prescaler divides the peripheral clock into half-periods of N+1 cycles, so each card clock period lasts 2(N+1) cycles. A second counter counts S+1 card clock periods per bit.

The framer receives a one-cycle `bit_tick_o` at the end of every bit. The bit rate is therefore the peripheral clock divided by (S+1)·2(N+1). When card clock output is enabled, `card_clk_o` carries a 50% duty square wave at S+1 times the bit rate. When it is disabled, the output is held low. New S or N values are picked up at bit boundaries, so the bit in progress always finishes with the old values. While `run_i` is low, all counting is held cleared.

Top module: `sc_clkgen`

## Requirements
- R1: While `run_i` is high, `bit_tick_o` pulses for exactly one cycle every (S+1)·2·(N+1) peripheral clock cycles. The first pulse after `run_i` rises comes in the last cycle of a full bit.
- R2: With output enabled, `card_clk_o` is low for N+1 cycles and then high for N+1 cycles, repeating. Each bit starts with the low half, and each bit holds exactly S+1 rising edges of `card_clk_o`.
- R3: While `clk_out_en_i` is low, `card_clk_o` is low. Bit tick timing is unchanged by `clk_out_en_i`.
- R4: A change of `samp_i` or `pre_i` while running does not alter the bit in progress. It applies from the bit that starts after the next `bit_tick_o`.
- R5: While `run_i` is low, both outputs are low and all counters are cleared. After `run_i` rises, the first bit is a full-length bit.
- R6: After reset, both outputs are low.
- R7: The extreme settings work: S=0 with N=0 gives a tick every 2 cycles, and S=2047 with N=7 gives a tick every 32768 cycles with 2048 card clock periods per bit.
- R8: In a tick cycle, `card_clk_o` is high if output is enabled. In the cycle after a tick, `card_clk_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Enables counting; low holds the generator cleared |
| clk_out_en_i | input | 1 | Drives the card clock onto `card_clk_o` when high |
| samp_i | input | 11 | Sampling count S (card clock periods per bit minus one) |
| pre_i | input | 3 | Prescale count N (half card clock period minus one, in cycles) |
| bit_tick_o | output | 1 | One-cycle pulse at the end of every bit |
| card_clk_o | output | 1 | Card clock square wave, or low when disabled |

## Verification
The bound checker checks several rules on every cycle. It counts cycles and checks that the tick lands exactly at the end of each (S+1)·2(N+1)-cycle bit. It also checks that the tick lasts one cycle, that the card clock stays low while disabled or idle, that the tick lines up with the card clock falling edge, and that the latched settings stay frozen between bit boundaries. Other behaviour shows only in the bench scenarios. These cover the exact 50% waveform, the count of S+1 card clock edges per bit, the timing of a mid-bit setting change, a run interruption with a full first bit after it, and the minimum and maximum settings. The bench compares each of these cycle by cycle against an independent model.

// File: rtl/sc_clkgen_pkg.sv
package sc_clkgen_pkg;
  localparam int unsigned SAMP_W_DEF = 11;
  localparam int unsigned PRE_W_DEF  = 3;
endpackage

// File: rtl/sc_prescaler.sv
module sc_prescaler #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [W-1:0] div_i,
  output logic         tc_o
);
  logic [W-1:0] cnt_q;

  assign tc_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i || tc_o) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sc_period_ctr.sv
module sc_period_ctr #(
  parameter int unsigned W = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         step_i,
  input  logic [W-1:0] lim_i,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  assign wrap_o = step_i && (cnt_q == lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (wrap_o)  cnt_q <= '0;
    else if (step_i)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sc_setting_latch.sv
module sc_setting_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/sc_clkgen.sv
module sc_clkgen
  import sc_clkgen_pkg::*;
#(
  parameter int unsigned SAMP_W = SAMP_W_DEF,
  parameter int unsigned PRE_W  = PRE_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              clk_out_en_i,
  input  logic [SAMP_W-1:0] samp_i,
  input  logic [PRE_W-1:0]  pre_i,
  output logic              bit_tick_o,
  output logic              card_clk_o
);
  logic [SAMP_W-1:0] s_lat;
  logic [PRE_W-1:0]  n_lat;
  logic              half_tc;
  logic              phase_q;
  logic              wrap;
  logic              load;

  // settings follow inputs while idle, otherwise only at a bit boundary
  assign load = !run_i || wrap;

  sc_setting_latch #(.W(SAMP_W)) u_s_lat (
    .clk_i, .rst_ni, .load_i(load), .d_i(samp_i), .q_o(s_lat)
  );

  sc_setting_latch #(.W(PRE_W)) u_n_lat (
    .clk_i, .rst_ni, .load_i(load), .d_i(pre_i), .q_o(n_lat)
  );

  sc_prescaler #(.W(PRE_W)) u_pre (
    .clk_i, .rst_ni, .run_i, .div_i(n_lat), .tc_o(half_tc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      phase_q <= 1'b0;
    else if (!run_i)  phase_q <= 1'b0;
    else if (half_tc) phase_q <= ~phase_q;
  end

  // one card clock period ends when the high half expires
  sc_period_ctr #(.W(SAMP_W)) u_per (
    .clk_i, .rst_ni, .run_i,
    .step_i(half_tc && phase_q),
    .lim_i(s_lat),
    .wrap_o(wrap)
  );

  assign bit_tick_o = wrap;
  assign card_clk_o = phase_q && clk_out_en_i && run_i;
endmodule

// File: rtl/sc_clkgen_chk.sv
module sc_clkgen_chk #(
  parameter int unsigned SAMP_W = 11,
  parameter int unsigned PRE_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              run_i,
  input logic              clk_out_en_i,
  input logic              bit_tick_o,
  input logic              card_clk_o,
  input logic [SAMP_W-1:0] s_lat_i,
  input logic [PRE_W-1:0]  n_lat_i
);
  localparam int unsigned CW = SAMP_W + PRE_W + 2;
  logic [CW-1:0] cyc_q;
  logic [CW-1:0] last_c;

  assign last_c = CW'((32'(s_lat_i) + 1) * 2 * (32'(n_lat_i) + 1) - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cyc_q <= '0;
    else if (!run_i || bit_tick_o)   cyc_q <= '0;
    else                             cyc_q <= cyc_q + 1'b1;
  end

  p_tick_on_time_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |-> (run_i && cyc_q == last_c));

  p_tick_not_late_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cyc_q == last_c) |-> bit_tick_o);

  p_tick_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |=> !bit_tick_o);

  p_clk_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_out_en_i |-> !card_clk_o);

  p_idle_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (!bit_tick_o && !card_clk_o));

  p_setting_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !bit_tick_o) |=> ($stable(s_lat_i) && $stable(n_lat_i)));

  p_tick_clk_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_tick_o && clk_out_en_i) |-> card_clk_o);

  p_tick_then_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |=> !card_clk_o);
endmodule

bind sc_clkgen sc_clkgen_chk #(.SAMP_W(SAMP_W), .PRE_W(PRE_W)) u_chk (
  .clk_i(clk_i),
  .rst_ni(rst_ni),
  .run_i(run_i),
  .clk_out_en_i(clk_out_en_i),
  .bit_tick_o(bit_tick_o),
  .card_clk_o(card_clk_o),
  .s_lat_i(s_lat),
  .n_lat_i(n_lat)
);

// File: tb/sc_clkgen_tb_top.sv
`timescale 1ns/1ps
module sc_clkgen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        oe = 1'b0;
  logic [10:0] samp = '0;
  logic [2:0]  pre = '0;
  logic        tick;
  logic        card_clk;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sc_clkgen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .clk_out_en_i(oe),
    .samp_i(samp), .pre_i(pre), .bit_tick_o(tick), .card_clk_o(card_clk)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: position within the bit and the settings in force
  int t = 0, sl = 0, nl = 0;
  function automatic int bit_len();
    return (sl + 1) * 2 * (nl + 1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t = 0; sl = 0; nl = 0;
    end else if (!run || t == bit_len() - 1) begin
      t = 0; sl = int'(samp); nl = int'(pre);
    end else begin
      t++;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      automatic bit e_tick = run && (t == bit_len() - 1);
      automatic bit e_clk  = run && oe && (((t / (nl + 1)) % 2) == 1);
      chk(tick == e_tick, "R1 tick timing", int'(tick), int'(e_tick));
      chk(card_clk == e_clk, "R2 card clock waveform", int'(card_clk), int'(e_clk));
    end
  end

  task automatic drive(input bit r, input bit o, input int s, input int n);
    @(posedge clk); #1;
    run = r; oe = o; samp = 11'(s); pre = 3'(n);
  endtask

  task automatic wait_tick();
    int lim = 0;
    do begin @(negedge clk); lim++; end while (!tick && lim < 70000);
  endtask

  task automatic next_gap(output int gap, output int rises);
    logic prev;
    gap = 0; rises = 0; prev = card_clk;
    do begin
      @(negedge clk);
      gap++;
      if (card_clk && !prev) rises++;
      prev = card_clk;
    end while (!tick && gap < 70000);
  endtask

  task automatic restart(input bit o, input int s, input int n);
    drive(1'b0, o, s, n);
    drive(1'b0, o, s, n);
    drive(1'b1, o, s, n);
  endtask

  int gap, rises;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(tick == 1'b0, "R6 reset tick", int'(tick), 0);
    chk(card_clk == 1'b0, "R6 reset card clock", int'(card_clk), 0);

    // R1 / R2: S=3, N=1 -> 16-cycle bit, 4 card clock periods
    restart(1'b1, 3, 1);
    next_gap(gap, rises);
    chk(gap == 16, "R1 first bit after run is full", gap, 16);
    chk(rises == 4, "R2 edges in first bit", rises, 4);
    next_gap(gap, rises);
    chk(gap == 16, "R1 bit period", gap, 16);
    chk(rises == 4, "R2 card clock edges per bit", rises, 4);

    // R7: minimum settings
    restart(1'b1, 0, 0);
    wait_tick();
    next_gap(gap, rises);
    chk(gap == 2, "R7 min bit period", gap, 2);
    chk(rises == 1, "R7 min edges per bit", rises, 1);

    // R3: clock output disabled, tick unchanged
    restart(1'b0, 2, 1);
    wait_tick();
    next_gap(gap, rises);
    chk(gap == 12, "R3 tick period with output off", gap, 12);
    chk(rises == 0, "R3 no card clock edges", rises, 0);
    drive(1'b1, 1'b1, 2, 1);
    wait_tick();
    next_gap(gap, rises);
    chk(rises == 3, "R3 output re-enabled", rises, 3);

    // R4: change settings mid-bit
    restart(1'b1, 3, 1);
    wait_tick();
    repeat (2) @(posedge clk);
    drive(1'b1, 1'b1, 1, 0);
    next_gap(gap, rises);
    chk(gap == 14, "R4 current bit keeps old settings", gap, 14);
    next_gap(gap, rises);
    chk(gap == 4, "R4 new settings after boundary", gap, 4);
    chk(rises == 2, "R4 new edges per bit", rises, 2);

    // R5: stop mid-bit, then resume
    restart(1'b1, 4, 2);
    wait_tick();
    repeat (4) @(posedge clk);
    drive(1'b0, 1'b1, 4, 2);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(tick == 1'b0, "R5 idle tick", int'(tick), 0);
      chk(card_clk == 1'b0, "R5 idle card clock", int'(card_clk), 0);
    end
    drive(1'b1, 1'b1, 4, 2);
    next_gap(gap, rises);
    chk(gap == 30, "R5 full bit after resume", gap, 30);
    chk(rises == 5, "R5 edges after resume", rises, 5);

    // R7: maximum settings
    restart(1'b1, 2047, 7);
    next_gap(gap, rises);
    chk(gap == 32768, "R7 max bit period", gap, 32768);
    chk(rises == 2048, "R7 max edges per bit", rises, 2048);

    // R8: tick alignment with card clock
    restart(1'b1, 1, 2);
    wait_tick();
    chk(card_clk == 1'b1, "R8 card clock high at tick", int'(card_clk), 1);
    @(negedge clk);
    chk(card_clk == 1'b0, "R8 card clock low after tick", int'(card_clk), 0);

    drive(1'b0, 1'b0, 0, 0);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1500000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0t expected=done", $time);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule